// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of an on-chip successive-approximation analog-to-digital converter. Software launches a conversion by raising a start control and then dropping it. While the start control stays high, the converter is held in reset. When the start control falls, the block runs one sample step and then resolves a 12-bit code one bit per converter clock. The converter clock comes from the system clock through a selectable divider. The block drives a trial code to an external DAC and reads back the verdict of an external comparator.

Progress is reported through an active-low end-of-conversion status. It reads 1 while a conversion is pending or held, and hardware clears it to 0 when the code is resolved. At that moment the final code is latched into a result register and an interrupt request flag is set. The flag only reaches the interrupt output when the interrupt enable is high.

An 8-bit pin-configuration register marks which port pins act as analog inputs. The selected pin n is routed to analog channel 8+n. A pin left in digital mode is still converted if it is selected, but its analog-enable indication stays low.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `eoc_n` is 1, `result` is 0, `irq_flag` and `irq_out` are 0, and `ana_en` is 0.
- R2: A conversion starts only on the first clock edge that samples `start_in` at 0 after it was sampled at 1. From the cycle after that edge, `sample_en` is 1 until the first converter clock tick.
- R3: While `start_in` is sampled at 1, the converter is held in reset. `eoc_n` reads 1 in the following cycle, and no conversion completes or sets `irq_flag`.
- R4: `eoc_n` falls to 0 exactly 13×D system clock edges after the start edge of R2, where D is the divide ratio.
- R5: `div_sel` values 0 to 6 give D = 2^(div_sel+1), that is 2, 4, 8, 16, 32, 64 and 128. The value 7 stops the converter clock, so a running conversion makes no progress.
- R6: The bits are resolved MSB first. On each tick, the trial bit on `dac_code` is kept when `cmp_in` is 1 and cleared when it is 0. With `cmp_in = (V >= dac_code)`, the result equals V.
- R7: `result` changes only at a completion. An aborted or held conversion leaves it unchanged.
- R8: `irq_flag` is set at every completion and stays set until `irq_clr` is sampled at 1. If the set and the clear fall on the same edge, the set wins.
- R9: `irq_out` is 1 exactly when `irq_flag` and `irq_en` are both 1.
- R10: A new start pulse during a conversion aborts that conversion. The new conversion's timing of R4 counts from the new falling edge.
- R11: Writing with `cfg_wr` loads `cfg_wdata` into the pin-configuration register, and bit n drives `ana_en[n]`. `mux_ch` equals 8 + `chan_sel`, and `chan_ana_en` equals the configuration bit of the selected pin.
- R12: A selected pin whose configuration bit is 0 is still converted to a correct result, while `chan_ana_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Start control: high holds the converter in reset, falling launches a conversion |
| div_sel | input | 3 | Converter clock divider select (7 = stopped) |
| cmp_in | input | 1 | Comparator verdict: 1 when the input is at or above `dac_code` |
| chan_sel | input | 3 | Selected port pin |
| cfg_wr | input | 1 | Write strobe for the pin-configuration register |
| cfg_wdata | input | 8 | Pin-configuration write data |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the interrupt request flag |
| dac_code | output | 12 | Trial code for the DAC |
| sample_en | output | 1 | High during the sample phase |
| eoc_n | output | 1 | End-of-conversion status, 0 when done |
| result | output | 12 | Latched conversion result |
| irq_flag | output | 1 | Interrupt request flag |
| irq_out | output | 1 | Gated interrupt request |
| ana_en | output | 8 | Per-pin analog-mode enables |
| mux_ch | output | 4 | Analog channel number of the selected pin |
| chan_ana_en | output | 1 | Selected pin is configured as analog |

## Verification
A completion and a software clear of the interrupt flag can land on the same clock edge. The bench holds `irq_clr` high for the whole of a conversion, so the clear is present on the completion edge. In the cycle after `eoc_n` falls, the flag must read 1. A second pair is a restart pulse arriving while a conversion is running. There the bench checks that the older conversion never reports, and that the latency and result of the new one count from its own falling edge.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int RES_W     = 12;
    localparam int DIVSEL_W  = 3;
    localparam int PRE_CNT_W = 8;
    localparam int CONV_TICKS = RES_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SAMPLE,
        ST_CONV
    } sar_state_e;

    typedef struct packed {
        logic running;
        logic sampling;
        logic done;
    } sar_status_t;

    // Terminal count of the divider: ratio minus one, ratio = 2^(sel+1)
    function automatic logic [PRE_CNT_W-1:0] div_limit(input logic [DIVSEL_W-1:0] sel);
        logic [PRE_CNT_W:0] ratio;
        ratio = (PRE_CNT_W+1)'(2) << sel;
        return PRE_CNT_W'(ratio - (PRE_CNT_W+1)'(1));
    endfunction

    function automatic logic div_stopped(input logic [DIVSEL_W-1:0] sel);
        return sel == DIVSEL_W'(7);
    endfunction

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler
    import sar_pkg::*;
#(
    parameter int CNT_W = PRE_CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [DIVSEL_W-1:0] sel,
    output logic                tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             stop;

    always_comb begin
        limit = CNT_W'(div_limit(sel));
        stop  = div_stopped(sel);
        tick  = run && !stop && (cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!stop) begin
            cnt <= (cnt >= limit) ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         tick,
    input  logic         cmp_in,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] result,
    output logic         eoc_n,
    output sar_status_t  status
);
    localparam int IDX_W = $clog2(W);

    sar_state_e       state;
    logic             start_q;
    logic [W-1:0]     acc;
    logic [IDX_W-1:0] idx;
    logic [W-1:0]     cur_bit;
    logic [W-1:0]     low_bit;
    logic [W-1:0]     resolved;
    logic             fall;
    logic             last_step;

    always_comb begin
        cur_bit = '0;
        cur_bit[idx] = 1'b1;
        low_bit  = cur_bit >> 1;
        resolved = cmp_in ? acc : (acc & ~cur_bit);
        fall     = !start && start_q;
        last_step = (state == ST_CONV) && tick && (idx == '0) && !start;
        status.running  = (state == ST_SAMPLE) || (state == ST_CONV);
        status.sampling = (state == ST_SAMPLE);
        status.done     = last_step;
        dac_code = acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            start_q <= 1'b0;
            acc     <= '0;
            idx     <= '0;
            result  <= '0;
            eoc_n   <= 1'b1;
        end else begin
            start_q <= start;
            if (start) begin
                state <= ST_HOLD;
                eoc_n <= 1'b1;
                acc   <= '0;
            end else if (fall) begin
                state <= ST_SAMPLE;
                eoc_n <= 1'b1;
                acc   <= '0;
            end else begin
                case (state)
                    ST_SAMPLE: if (tick) begin
                        state <= ST_CONV;
                        acc   <= W'(1) << (W-1);
                        idx   <= IDX_W'(W-1);
                    end
                    ST_CONV: if (tick) begin
                        if (idx == '0) begin
                            acc    <= resolved;
                            result <= resolved;
                            eoc_n  <= 1'b0;
                            state  <= ST_IDLE;
                        end else begin
                            acc <= resolved | low_bit;
                            idx <= idx - IDX_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sar_irq.sv
module sar_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    assign req = flag && en;
endmodule

// File: rtl/sar_pincfg.sv
module sar_pincfg #(
    parameter int PORT_W  = 8,
    parameter int CH_BASE = 8,
    localparam int SEL_W  = $clog2(PORT_W),
    localparam int CH_W   = $clog2(CH_BASE + PORT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [PORT_W-1:0] wdata,
    input  logic [SEL_W-1:0]  sel,
    output logic [PORT_W-1:0] ana_en,
    output logic [CH_W-1:0]   mux_ch,
    output logic              sel_ana
);
    logic [PORT_W-1:0] cfg;

    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (wr) cfg <= wdata;
    end

    assign ana_en  = cfg;
    assign sel_ana = cfg[sel];
    assign mux_ch  = CH_W'(CH_BASE) + CH_W'(sel);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import sar_pkg::*;
#(
    parameter int W       = RES_W,
    parameter int PORT_W  = 8,
    parameter int CH_BASE = 8,
    localparam int SEL_W  = $clog2(PORT_W),
    localparam int CH_W   = $clog2(CH_BASE + PORT_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_in,
    input  logic [DIVSEL_W-1:0] div_sel,
    input  logic                cmp_in,
    input  logic [SEL_W-1:0]    chan_sel,
    input  logic                cfg_wr,
    input  logic [PORT_W-1:0]   cfg_wdata,
    input  logic                irq_en,
    input  logic                irq_clr,
    output logic [W-1:0]        dac_code,
    output logic                sample_en,
    output logic                eoc_n,
    output logic [W-1:0]        result,
    output logic                irq_flag,
    output logic                irq_out,
    output logic [PORT_W-1:0]   ana_en,
    output logic [CH_W-1:0]     mux_ch,
    output logic                chan_ana_en
);
    sar_status_t st;
    logic        tick;

    sar_prescaler u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (st.running),
        .sel  (div_sel),
        .tick (tick)
    );

    sar_engine #(.W(W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start_in),
        .tick     (tick),
        .cmp_in   (cmp_in),
        .dac_code (dac_code),
        .result   (result),
        .eoc_n    (eoc_n),
        .status   (st)
    );

    sar_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_evt (st.done),
        .clr     (irq_clr),
        .en      (irq_en),
        .flag    (irq_flag),
        .req     (irq_out)
    );

    sar_pincfg #(.PORT_W(PORT_W), .CH_BASE(CH_BASE)) u_pin (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .sel     (chan_sel),
        .ana_en  (ana_en),
        .mux_ch  (mux_ch),
        .sel_ana (chan_ana_en)
    );

    assign sample_en = st.sampling;
endmodule

// File: rtl/sar_ctrl_checker.sv
module sar_ctrl_checker #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         start_in,
    input logic [2:0]   div_sel,
    input logic         eoc_n,
    input logic [W-1:0] dac_code,
    input logic [W-1:0] result,
    input logic         irq_flag,
    input logic         irq_en,
    input logic         irq_out
);
    p_hold_status_r3: assert property (@(posedge clk) disable iff (rst)
        start_in |=> eoc_n);

    p_flag_at_done_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc_n) |-> irq_flag);

    p_gated_req_r9: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (irq_flag && irq_en));

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $fell(eoc_n));

    p_stopped_clock_r5: assert property (@(posedge clk) disable iff (rst)
        (div_sel == 3'd7 && !start_in && !$past(start_in)) |=> ($stable(dac_code) && $stable(eoc_n)));
endmodule

bind adc_seq_ctrl sar_ctrl_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_in (start_in),
    .div_sel  (div_sel),
    .eoc_n    (eoc_n),
    .dac_code (dac_code),
    .result   (result),
    .irq_flag (irq_flag),
    .irq_en   (irq_en),
    .irq_out  (irq_out)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_in = 1'b0;
    logic [2:0]  div_sel = 3'd0;
    logic        cmp_in;
    logic [2:0]  chan_sel = 3'd0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic [11:0] dac_code;
    logic        sample_en;
    logic        eoc_n;
    logic [11:0] result;
    logic        irq_flag;
    logic        irq_out;
    logic [7:0]  ana_en;
    logic [3:0]  mux_ch;
    logic        chan_ana_en;

    logic [11:0] analog = 12'h000;
    longint      cyc = 0;
    int          checks = 0;
    int          errors = 0;
    int          q_val[$];
    longint      q_due[$];
    logic        eoc_prev = 1'b1;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign cmp_in = (analog >= dac_code);

    adc_seq_ctrl uut (
        .clk(clk), .rst(rst), .start_in(start_in), .div_sel(div_sel),
        .cmp_in(cmp_in), .chan_sel(chan_sel), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .irq_en(irq_en), .irq_clr(irq_clr),
        .dac_code(dac_code), .sample_en(sample_en), .eoc_n(eoc_n),
        .result(result), .irq_flag(irq_flag), .irq_out(irq_out),
        .ana_en(ana_en), .mux_ch(mux_ch), .chan_ana_en(chan_ana_en)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint ratio(input logic [2:0] sel);
        return longint'(2) << sel;
    endfunction

    // Driver: raise start, hold it, drop it; optionally push the expected completion.
    task automatic pulse(input logic [2:0] sel, input logic [11:0] v,
                         input int hold, input bit expect_done);
        @(negedge clk);
        div_sel  = sel;
        analog   = v;
        start_in = 1'b1;
        repeat (hold) @(negedge clk);
        start_in = 1'b0;
        @(negedge clk);
        if (expect_done) begin
            q_val.push_back(int'(v));
            q_due.push_back(cyc + 13 * ratio(sel));
        end
    endtask

    task automatic wait_drained();
        for (int i = 0; i < 5000; i++) begin
            if (q_val.size() == 0) break;
            @(negedge clk);
        end
        check("R4 queue drained", q_val.size(), 0);
    endtask

    // Monitor: every falling eoc_n must match the oldest expectation.
    always @(negedge clk) begin
        if (!rst) begin
            if (eoc_prev && !eoc_n) begin
                if (q_val.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R10 unexpected completion actual=%0h expected=none", result);
                end else begin
                    check("R6 result", result, q_val.pop_front());
                    check("R4 latency", cyc, q_due.pop_front());
                end
            end
            eoc_prev = eoc_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 eoc_n", eoc_n, 1);
        check("R1 result", result, 0);
        check("R1 irq_flag", irq_flag, 0);
        check("R1 irq_out", irq_out, 0);
        check("R1 ana_en", ana_en, 0);

        // First conversion, interrupt disabled
        pulse(3'd0, 12'hA5C, 1, 1'b1);
        check("R2 sample_en", sample_en, 1);
        check("R2 eoc_n busy", eoc_n, 1);
        wait_drained();
        check("R8 flag set", irq_flag, 1);
        check("R9 gated off", irq_out, 0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R9 gated on", irq_out, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R8 flag cleared", irq_flag, 0);
        check("R9 out cleared", irq_out, 0);

        // Several ratios and values (R5, R6)
        pulse(3'd1, 12'hFFF, 1, 1'b1); wait_drained();
        pulse(3'd2, 12'h000, 1, 1'b1); wait_drained();
        pulse(3'd6, 12'h800, 1, 1'b1); wait_drained();
        pulse(3'd3, 12'h123, 1, 1'b1); wait_drained();
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

        // Long hold of start: converter held in reset (R3)
        @(negedge clk);
        div_sel = 3'd0;
        analog = 12'h456;
        start_in = 1'b1;
        repeat (200) @(negedge clk);
        check("R3 eoc_n held", eoc_n, 1);
        check("R3 no flag", irq_flag, 0);
        check("R7 result kept", result, 12'h123);
        start_in = 1'b0;
        @(negedge clk);
        q_val.push_back(12'h456);
        q_due.push_back(cyc + 13 * ratio(3'd0));
        wait_drained();

        // Abort and restart (R10, R7)
        pulse(3'd2, 12'h3C3, 1, 1'b0);
        repeat (50) @(negedge clk);
        check("R10 still busy", eoc_n, 1);
        check("R7 result unchanged", result, 12'h456);
        pulse(3'd2, 12'h3C4, 1, 1'b1);
        wait_drained();

        // Stopped converter clock (R5)
        pulse(3'd7, 12'h777, 1, 1'b0);
        repeat (3000) @(negedge clk);
        check("R5 stopped busy", eoc_n, 1);
        check("R5 stopped result", result, 12'h3C4);
        pulse(3'd0, 12'h777, 1, 1'b1);
        wait_drained();

        // Completion and clear on the same edge: set wins (R8)
        irq_clr = 1'b1;
        pulse(3'd1, 12'h055, 1, 1'b1);
        for (int i = 0; i < 2000; i++) begin
            if (!eoc_n) break;
            @(negedge clk);
        end
        check("R8 set wins", irq_flag, 1);
        irq_clr = 1'b0;
        wait_drained();

        // Pin configuration and channel mapping (R11, R12)
        @(negedge clk);
        cfg_wdata = 8'h5A;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R11 ana_en", ana_en, 8'h5A);
        chan_sel = 3'd1;
        #1;
        check("R11 chan_ana_en", chan_ana_en, 1);
        check("R11 mux_ch", mux_ch, 9);
        chan_sel = 3'd0;
        #1;
        check("R11 mux_ch base", mux_ch, 8);
        check("R12 digital pin", chan_ana_en, 0);
        pulse(3'd1, 12'h9AB, 1, 1'b1);
        wait_drained();
        check("R12 converted", result, 12'h9AB);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule